// File: doc/BRIEF.md
# Trap and Interrupt Entry Controller

This block sits beside a processor's control path and works out what happens when an exception is raised or an interrupt becomes takeable. Each cycle it combines the pending and enable interrupt masks with the current privilege level and the global interrupt-enable bits. From that it finds the interrupt that may be taken, if any. It then routes that interrupt, or an incoming exception, to one of four places: supervisor mode through delegation, machine mode, debug-mode entry on a software breakpoint, or the debug exception address while a debug session is already active.

The block does not hold the architectural registers. It reads their current values on its inputs and, one clock edge after the request, presents a registered update bundle. The bundle carries the next PC and privilege level, one strobe per register set (supervisor, machine or debug), the cause, return address and faulting address to store, the new status fields, and a one-cycle pulse that clears the load reservation. The surrounding core commits the update into its own state.

Top module: `trap_entry_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `upd_vld_o`, `resv_clr_o`, `wr_sup_o`, `wr_mach_o`, `wr_dbg_o` and `bad_we_o` are 0, whatever the request inputs do.
- R2: An interrupt is a candidate only where both the pending and the enable bits are 1. Any request (candidate interrupt that is enabled, or `exc_req_i`) gives `upd_vld_o` = 1 on the edge after it is presented. With no request, `upd_vld_o` stays 0.
- R3: A non-delegated interrupt (its `irq_deleg_i` bit is 0) is enabled when privilege (user = 0, supervisor = 1, machine = 3) is below machine, or is machine with `st_mie_i` = 1.
- R4: A delegated interrupt (its `irq_deleg_i` bit is 1) is enabled when privilege is user, or is supervisor with `st_sie_i` = 1. At machine level it is never taken.
- R5: Among enabled interrupts the lowest index wins. The cause is that index with bit XLEN-1 set, and the return address is `cur_pc_i`.
- R6: When an interrupt is enabled in the same cycle as `exc_req_i`, the interrupt is taken and the exception is not.
- R7: An exception with cause 3 (breakpoint) whose bit `dbg_ebreak_i[priv_i]` is 1 enters debug mode. In that case `wr_dbg_o` = 1, next PC = DBG_ROM_START, next privilege = machine, `dbg_cause_o` = 1, `dbg_prv_o` = the prior privilege, `epc_o` = `cur_pc_i`, and the reservation is not cleared. This check comes before R8.
- R8: Any other trap while `dbg_cause_i` is nonzero gives next PC = DBG_ROM_EXC. Privilege and status pass through unchanged, no register-set strobe is raised, and the reservation is not cleared.
- R9: A trap goes to supervisor mode only when privilege is user or supervisor and the delegation bit for its cause is set. Interrupts index `irq_deleg_i` by their index. Exceptions index `exc_deleg_i` by their cause, and a cause of XLEN or above is never delegated.
- R10: Supervisor entry gives `wr_sup_o` = 1, next PC = `stvec_i`, and next privilege = supervisor. It stores the cause and return address. SPIE takes the prior level's enable bit (`st_uie_i` for user, `st_sie_i` for supervisor), SPP takes privilege bit 0, and SIE is cleared. The machine status fields pass through.
- R11: Machine entry gives `wr_mach_o` = 1, next PC = `mtvec_i`, and next privilege = machine. It stores the cause and return address. MPIE takes the prior level's enable bit, MPP takes the prior privilege, and MIE is cleared. The supervisor status fields pass through.
- R12: `bad_we_o` is 1 only on supervisor or machine entry for an exception with `exc_bad_vld_i` = 1, and `bad_o` then carries `exc_bad_i`. Interrupts never write it.
- R13: `resv_clr_o` pulses for exactly the cycles with a supervisor or machine entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| priv_i | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| cur_pc_i | input | XLEN | PC of the instruction at the boundary |
| irq_pend_i | input | IRQ_W | Pending interrupt mask |
| irq_en_i | input | IRQ_W | Interrupt enable mask |
| irq_deleg_i | input | IRQ_W | Interrupt delegation mask |
| exc_deleg_i | input | XLEN | Exception delegation mask |
| st_uie_i | input | 1 | User interrupt-enable status bit |
| st_sie_i | input | 1 | Supervisor interrupt-enable status bit |
| st_spie_i | input | 1 | Supervisor prior-enable status bit |
| st_spp_i | input | 1 | Supervisor prior-privilege status bit |
| st_mie_i | input | 1 | Machine interrupt-enable status bit |
| st_mpie_i | input | 1 | Machine prior-enable status bit |
| st_mpp_i | input | 2 | Machine prior-privilege status field |
| dbg_ebreak_i | input | 4 | Breakpoint-to-debug enable, indexed by privilege |
| dbg_cause_i | input | 3 | Current debug cause; nonzero means a debug session is active |
| stvec_i | input | XLEN | Supervisor trap vector |
| mtvec_i | input | XLEN | Machine trap vector |
| exc_req_i | input | 1 | Exception request |
| exc_cause_i | input | XLEN | Exception cause |
| exc_epc_i | input | XLEN | Exception return address |
| exc_bad_vld_i | input | 1 | Exception carries a faulting address |
| exc_bad_i | input | XLEN | Faulting address |
| upd_vld_o | output | 1 | Update bundle valid (one cycle) |
| nxt_pc_o | output | XLEN | Next PC |
| nxt_priv_o | output | 2 | Next privilege |
| wr_sup_o | output | 1 | Write the supervisor cause/return/address set |
| wr_mach_o | output | 1 | Write the machine cause/return/address set |
| wr_dbg_o | output | 1 | Debug entry: write debug PC, cause and privilege |
| cause_o | output | XLEN | Cause to store |
| epc_o | output | XLEN | Return address (debug PC on debug entry) |
| bad_we_o | output | 1 | Write the faulting-address register |
| bad_o | output | XLEN | Faulting address to store |
| st_sie_o | output | 1 | New SIE |
| st_spie_o | output | 1 | New SPIE |
| st_spp_o | output | 1 | New SPP |
| st_mie_o | output | 1 | New MIE |
| st_mpie_o | output | 1 | New MPIE |
| st_mpp_o | output | 2 | New MPP |
| dbg_cause_o | output | 3 | Debug cause to record on debug entry |
| dbg_prv_o | output | 2 | Prior privilege to record on debug entry |
| resv_clr_o | output | 1 | Clear the load reservation (one cycle) |

## Verification
The assertions watch the structural invariants every cycle. A request is always answered on the next edge. No more than one register set is written at a time. Supervisor and machine entry land at the right privilege with the matching enable cleared and the reservation pulse raised. The faulting-address strobe appears only with a trap entry. An active debug session diverts ordinary traps to the debug exception address without touching any state. The selected interrupt is always both pending and enabled.

Only the bench scenarios show that the values are right. That covers which interrupt wins when delegated and non-delegated sources mix, how the enable rules turn over at each privilege level, the breakpoint taking precedence over an active debug session, the return address coming from the PC rather than the exception input, and the pass-through of the status fields the entry leaves alone.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

   localparam logic [1:0] PRV_U = 2'd0;
   localparam logic [1:0] PRV_S = 2'd1;
   localparam logic [1:0] PRV_M = 2'd3;

   // exception code of a breakpoint, and debug cause for a software breakpoint
   localparam int unsigned CAUSE_BRK = 3;
   localparam logic [2:0]  DBGC_SWBP = 3'd1;

   typedef enum logic [2:0] {
      DST_NONE,
      DST_SUP,
      DST_MACH,
      DST_DBG_ENTER,
      DST_DBG_EXC
   } dest_e;

endpackage

// File: rtl/trap_irq_sel.sv
module trap_irq_sel
   import trap_entry_pkg::*;
#(
   parameter int IRQ_W     = 12,
   parameter bit ONEHOT_ENC = 1'b1,
   localparam int IW        = $clog2(IRQ_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       priv_i,
   input  logic [IRQ_W-1:0] pend_i,
   input  logic [IRQ_W-1:0] ena_i,
   input  logic [IRQ_W-1:0] deleg_i,
   input  logic             mie_i,
   input  logic             sie_i,
   output logic             any_o,
   output logic [IW-1:0]    idx_o
);

   logic             m_ok, s_ok;
   logic [IRQ_W-1:0] cand, live;

   always_comb begin
      m_ok = (priv_i != PRV_M) || mie_i;
      s_ok = (priv_i == PRV_U) || ((priv_i == PRV_S) && sie_i);
      cand = pend_i & ena_i;
      live = (cand & ~deleg_i & {IRQ_W{m_ok}}) | (cand & deleg_i & {IRQ_W{s_ok}});
   end

   assign any_o = |live;

   generate
      if (ONEHOT_ENC) begin : g_isolate
         logic [IRQ_W-1:0] low;
         assign low = live & (~live + IRQ_W'(1));
         always_comb begin
            idx_o = '0;
            for (int i = 0; i < IRQ_W; i++)
               if (low[i]) idx_o = idx_o | IW'(i);
         end
      end else begin : g_scan
         always_comb begin
            idx_o = '0;
            for (int i = IRQ_W - 1; i >= 0; i--)
               if (live[i]) idx_o = IW'(i);
         end
      end
   endgenerate

   // R2: no candidate means nothing is selected
   assert_no_cand_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend_i & ena_i) == '0) |-> !any_o);

   // R5: the chosen index is pending and enabled
   assert_pick_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
      any_o |-> (pend_i[idx_o] && ena_i[idx_o]));

   // R4: at machine level a delegated source alone never fires
   assert_deleg_mmode_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((priv_i == PRV_M) && ((pend_i & ena_i & ~deleg_i) == '0)) |-> !any_o);

endmodule

// File: rtl/trap_route.sv
module trap_route
   import trap_entry_pkg::*;
#(
   parameter int XLEN  = 32,
   parameter int IRQ_W = 12,
   localparam int IW    = $clog2(IRQ_W),
   localparam int XW    = $clog2(XLEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_i,
   input  logic             is_irq_i,
   input  logic [IW-1:0]    irq_idx_i,
   input  logic [XLEN-1:0]  exc_cause_i,
   input  logic [1:0]       priv_i,
   input  logic [3:0]       ebreak_i,
   input  logic             dbg_busy_i,
   input  logic [IRQ_W-1:0] ideleg_i,
   input  logic [XLEN-1:0]  edeleg_i,
   output dest_e            dest_o
);

   logic brk_hit, exc_in_range, deleg_hit, low_priv;

   always_comb begin
      brk_hit      = !is_irq_i && (exc_cause_i == XLEN'(CAUSE_BRK)) && ebreak_i[priv_i];
      exc_in_range = (exc_cause_i >> XW) == '0;
      deleg_hit    = is_irq_i ? ideleg_i[irq_idx_i]
                              : (exc_in_range && edeleg_i[exc_cause_i[XW-1:0]]);
      low_priv     = (priv_i == PRV_U) || (priv_i == PRV_S);

      if (!req_i)                   dest_o = DST_NONE;
      else if (brk_hit)             dest_o = DST_DBG_ENTER;
      else if (dbg_busy_i)          dest_o = DST_DBG_EXC;
      else if (low_priv && deleg_hit) dest_o = DST_SUP;
      else                          dest_o = DST_MACH;
   end

   // R9: supervisor routing only from user or supervisor level
   assert_sup_from_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (dest_o == DST_SUP) |-> (priv_i == PRV_U || priv_i == PRV_S));

   // R7: interrupts never enter debug through the breakpoint path
   assert_irq_no_dbg_R7: assert property (@(posedge clk) disable iff (!rst_n)
      is_irq_i |-> (dest_o != DST_DBG_ENTER));

endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
   import trap_entry_pkg::*;
#(
   parameter int              XLEN          = 32,
   parameter int              IRQ_W         = 12,
   parameter bit              ONEHOT_ENC    = 1'b1,
   parameter logic [XLEN-1:0] DBG_ROM_START = XLEN'(32'h0000_0800),
   parameter logic [XLEN-1:0] DBG_ROM_EXC   = XLEN'(32'h0000_0808),
   localparam int             IW            = $clog2(IRQ_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       priv_i,
   input  logic [XLEN-1:0]  cur_pc_i,
   input  logic [IRQ_W-1:0] irq_pend_i,
   input  logic [IRQ_W-1:0] irq_en_i,
   input  logic [IRQ_W-1:0] irq_deleg_i,
   input  logic [XLEN-1:0]  exc_deleg_i,
   input  logic             st_uie_i,
   input  logic             st_sie_i,
   input  logic             st_spie_i,
   input  logic             st_spp_i,
   input  logic             st_mie_i,
   input  logic             st_mpie_i,
   input  logic [1:0]       st_mpp_i,
   input  logic [3:0]       dbg_ebreak_i,
   input  logic [2:0]       dbg_cause_i,
   input  logic [XLEN-1:0]  stvec_i,
   input  logic [XLEN-1:0]  mtvec_i,
   input  logic             exc_req_i,
   input  logic [XLEN-1:0]  exc_cause_i,
   input  logic [XLEN-1:0]  exc_epc_i,
   input  logic             exc_bad_vld_i,
   input  logic [XLEN-1:0]  exc_bad_i,
   output logic             upd_vld_o,
   output logic [XLEN-1:0]  nxt_pc_o,
   output logic [1:0]       nxt_priv_o,
   output logic             wr_sup_o,
   output logic             wr_mach_o,
   output logic             wr_dbg_o,
   output logic [XLEN-1:0]  cause_o,
   output logic [XLEN-1:0]  epc_o,
   output logic             bad_we_o,
   output logic [XLEN-1:0]  bad_o,
   output logic             st_sie_o,
   output logic             st_spie_o,
   output logic             st_spp_o,
   output logic             st_mie_o,
   output logic             st_mpie_o,
   output logic [1:0]       st_mpp_o,
   output logic [2:0]       dbg_cause_o,
   output logic [1:0]       dbg_prv_o,
   output logic             resv_clr_o
);

   generate
      if (IRQ_W < 2 || IRQ_W > XLEN) begin : g_bad_irq_w
         $error("trap_entry_ctrl: IRQ_W must lie in 2..XLEN");
      end
      if (XLEN < 8) begin : g_bad_xlen
         $error("trap_entry_ctrl: XLEN too small");
      end
   endgenerate

   typedef struct packed {
      logic            vld;
      logic [XLEN-1:0] pc;
      logic [1:0]      priv;
      logic            wsup, wmach, wdbg;
      logic [XLEN-1:0] cause, epc;
      logic            bwe;
      logic [XLEN-1:0] bad;
      logic            sie, spie, spp, mie, mpie;
      logic [1:0]      mpp;
      logic [2:0]      dcause;
      logic [1:0]      dprv;
      logic            resv;
   } upd_t;

   logic            irq_any;
   logic [IW-1:0]   irq_idx;
   logic            req, prior_ie;
   logic [XLEN-1:0] cause_sel, epc_sel;
   dest_e           dest;
   upd_t            d, q;

   trap_irq_sel #(.IRQ_W(IRQ_W), .ONEHOT_ENC(ONEHOT_ENC)) u_sel (
      .clk     (clk),
      .rst_n   (rst_n),
      .priv_i  (priv_i),
      .pend_i  (irq_pend_i),
      .ena_i   (irq_en_i),
      .deleg_i (irq_deleg_i),
      .mie_i   (st_mie_i),
      .sie_i   (st_sie_i),
      .any_o   (irq_any),
      .idx_o   (irq_idx)
   );

   assign req       = irq_any || exc_req_i;
   assign cause_sel = irq_any ? ((XLEN'(1) << (XLEN - 1)) | XLEN'(irq_idx)) : exc_cause_i;
   assign epc_sel   = irq_any ? cur_pc_i : exc_epc_i;

   trap_route #(.XLEN(XLEN), .IRQ_W(IRQ_W)) u_route (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_i       (req),
      .is_irq_i    (irq_any),
      .irq_idx_i   (irq_idx),
      .exc_cause_i (exc_cause_i),
      .priv_i      (priv_i),
      .ebreak_i    (dbg_ebreak_i),
      .dbg_busy_i  (dbg_cause_i != 3'd0),
      .ideleg_i    (irq_deleg_i),
      .edeleg_i    (exc_deleg_i),
      .dest_o      (dest)
   );

   always_comb begin
      unique case (priv_i)
         PRV_U:   prior_ie = st_uie_i;
         PRV_S:   prior_ie = st_sie_i;
         PRV_M:   prior_ie = st_mie_i;
         default: prior_ie = 1'b0;
      endcase
   end

   always_comb begin
      d       = '0;
      d.vld   = req;
      d.priv  = priv_i;
      d.cause = cause_sel;
      d.epc   = epc_sel;
      d.bad   = (!irq_any && exc_bad_vld_i) ? exc_bad_i : '0;
      d.sie   = st_sie_i;
      d.spie  = st_spie_i;
      d.spp   = st_spp_i;
      d.mie   = st_mie_i;
      d.mpie  = st_mpie_i;
      d.mpp   = st_mpp_i;
      unique case (dest)
         DST_DBG_ENTER: begin
            d.pc     = DBG_ROM_START;
            d.priv   = PRV_M;
            d.wdbg   = 1'b1;
            d.dcause = DBGC_SWBP;
            d.dprv   = priv_i;
            d.epc    = cur_pc_i;
         end
         DST_DBG_EXC: d.pc = DBG_ROM_EXC;
         DST_SUP: begin
            d.pc    = stvec_i;
            d.priv  = PRV_S;
            d.wsup  = 1'b1;
            d.bwe   = !irq_any && exc_bad_vld_i;
            d.spie  = prior_ie;
            d.spp   = priv_i[0];
            d.sie   = 1'b0;
            d.resv  = 1'b1;
         end
         DST_MACH: begin
            d.pc    = mtvec_i;
            d.priv  = PRV_M;
            d.wmach = 1'b1;
            d.bwe   = !irq_any && exc_bad_vld_i;
            d.mpie  = prior_ie;
            d.mpp   = priv_i;
            d.mie   = 1'b0;
            d.resv  = 1'b1;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= '0;
      end else if (d.vld) begin
         q <= d;
      end else begin
         q.vld   <= 1'b0;
         q.wsup  <= 1'b0;
         q.wmach <= 1'b0;
         q.wdbg  <= 1'b0;
         q.bwe   <= 1'b0;
         q.resv  <= 1'b0;
      end
   end

   assign upd_vld_o   = q.vld;
   assign nxt_pc_o    = q.pc;
   assign nxt_priv_o  = q.priv;
   assign wr_sup_o    = q.wsup;
   assign wr_mach_o   = q.wmach;
   assign wr_dbg_o    = q.wdbg;
   assign cause_o     = q.cause;
   assign epc_o       = q.epc;
   assign bad_we_o    = q.bwe;
   assign bad_o       = q.bad;
   assign st_sie_o    = q.sie;
   assign st_spie_o   = q.spie;
   assign st_spp_o    = q.spp;
   assign st_mie_o    = q.mie;
   assign st_mpie_o   = q.mpie;
   assign st_mpp_o    = q.mpp;
   assign dbg_cause_o = q.dcause;
   assign dbg_prv_o   = q.dprv;
   assign resv_clr_o  = q.resv;

   // R2: every request is answered on the following edge
   assert_req_answered_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_req_i || irq_any) |=> upd_vld_o);

   // R8: at most one register set is written per update
   assert_one_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_sup_o, wr_mach_o, wr_dbg_o}));

   // R8: an active debug session diverts ordinary traps and leaves state alone
   assert_dbg_exc_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((exc_req_i || irq_any) && (dbg_cause_i != 3'd0) &&
       !(!irq_any && exc_cause_i == XLEN'(CAUSE_BRK) && dbg_ebreak_i[priv_i]))
      |=> (nxt_pc_o == DBG_ROM_EXC && !resv_clr_o && !wr_sup_o && !wr_mach_o
           && !wr_dbg_o && nxt_priv_o == $past(priv_i)));

   // R10: supervisor entry lands in supervisor mode with SIE cleared
   assert_sup_entry_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_sup_o |-> (nxt_priv_o == PRV_S && !st_sie_o && resv_clr_o));

   // R11: machine entry lands in machine mode with MIE cleared
   assert_mach_entry_R11: assert property (@(posedge clk) disable iff (!rst_n)
      wr_mach_o |-> (nxt_priv_o == PRV_M && !st_mie_o && resv_clr_o));

   // R12: the faulting address is written only together with a trap entry
   assert_bad_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
      bad_we_o |-> (wr_sup_o || wr_mach_o));

   // R13: the reservation pulse belongs to a valid update
   assert_resv_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
      resv_clr_o |-> upd_vld_o);

   // R7: debug entry goes to machine level and keeps the reservation
   assert_dbg_enter_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_dbg_o |-> (nxt_priv_o == PRV_M && dbg_cause_o == DBGC_SWBP && !resv_clr_o));

endmodule

// File: tb/trap_entry_ctrl_tb_top.sv
module trap_entry_ctrl_tb_top;

   localparam int          XLEN  = 32;
   localparam int          IRQ_W = 12;
   localparam logic [31:0] DROM  = 32'h0000_0800;
   localparam logic [31:0] DEXC  = 32'h0000_0808;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic [1:0]       prv;
   logic [31:0]      cur_pc, stvec, mtvec, edeleg, exc_cause, exc_epc, exc_bad;
   logic [IRQ_W-1:0] pend, ien, ideleg;
   logic             uie, sie_s, spie_s, spp_s, mie_s, mpie_s;
   logic [1:0]       mpp_s;
   logic [3:0]       ebrk;
   logic [2:0]       dbgc;
   logic             exc_req, bad_vld;

   logic             o_vld, o_wsup, o_wmach, o_wdbg, o_bwe, o_resv;
   logic [31:0]      o_pc, o_cause, o_epc, o_bad;
   logic [1:0]       o_priv, o_mpp, o_dprv;
   logic             o_sie, o_spie, o_spp, o_mie, o_mpie;
   logic [2:0]       o_dcause;

   trap_entry_ctrl #(.XLEN(XLEN), .IRQ_W(IRQ_W), .DBG_ROM_START(DROM), .DBG_ROM_EXC(DEXC)) dut_i (
      .clk(clk), .rst_n(rst_n), .priv_i(prv), .cur_pc_i(cur_pc),
      .irq_pend_i(pend), .irq_en_i(ien), .irq_deleg_i(ideleg), .exc_deleg_i(edeleg),
      .st_uie_i(uie), .st_sie_i(sie_s), .st_spie_i(spie_s), .st_spp_i(spp_s),
      .st_mie_i(mie_s), .st_mpie_i(mpie_s), .st_mpp_i(mpp_s),
      .dbg_ebreak_i(ebrk), .dbg_cause_i(dbgc), .stvec_i(stvec), .mtvec_i(mtvec),
      .exc_req_i(exc_req), .exc_cause_i(exc_cause), .exc_epc_i(exc_epc),
      .exc_bad_vld_i(bad_vld), .exc_bad_i(exc_bad),
      .upd_vld_o(o_vld), .nxt_pc_o(o_pc), .nxt_priv_o(o_priv),
      .wr_sup_o(o_wsup), .wr_mach_o(o_wmach), .wr_dbg_o(o_wdbg),
      .cause_o(o_cause), .epc_o(o_epc), .bad_we_o(o_bwe), .bad_o(o_bad),
      .st_sie_o(o_sie), .st_spie_o(o_spie), .st_spp_o(o_spp),
      .st_mie_o(o_mie), .st_mpie_o(o_mpie), .st_mpp_o(o_mpp),
      .dbg_cause_o(o_dcause), .dbg_prv_o(o_dprv), .resv_clr_o(o_resv)
   );

   typedef struct {
      bit          vld, wsup, wmach, wdbg, bwe, resv;
      logic [31:0] pc, cause, epc, bad;
      logic [1:0]  priv, mpp, dprv;
      bit          sie, spie, spp, mie, mpie;
      logic [2:0]  dcause;
      string       tag;
   } exp_t;

   exp_t sb_q[$];
   int   n_cmp = 0;
   int   n_bad = 0;
   bit   done  = 1'b0;

   function automatic exp_t model(string tag);
      exp_t             e;
      logic [IRQ_W-1:0] cand, live;
      bit               mok, sok, irq, pie, brk, dg;
      int               idx;
      logic [31:0]      cause, epc;
      e.tag = tag; e.vld = 0; e.wsup = 0; e.wmach = 0; e.wdbg = 0; e.bwe = 0; e.resv = 0;
      e.pc = '0; e.cause = '0; e.epc = '0; e.bad = '0; e.priv = prv;
      e.sie = sie_s; e.spie = spie_s; e.spp = spp_s; e.mie = mie_s; e.mpie = mpie_s;
      e.mpp = mpp_s; e.dprv = '0; e.dcause = '0;
      cand = pend & ien;
      mok  = (prv != 2'd3) || mie_s;
      sok  = (prv == 2'd0) || (prv == 2'd1 && sie_s);
      live = (cand & ~ideleg & {IRQ_W{mok}}) | (cand & ideleg & {IRQ_W{sok}});
      idx  = -1;
      for (int i = IRQ_W - 1; i >= 0; i--) if (live[i]) idx = i;
      irq   = (idx >= 0);
      e.vld = irq || exc_req;
      if (!e.vld) return e;
      cause = irq ? (32'h8000_0000 | 32'(idx)) : exc_cause;
      epc   = irq ? cur_pc : exc_epc;
      pie   = (prv == 2'd0) ? uie : (prv == 2'd1) ? sie_s : (prv == 2'd3) ? mie_s : 1'b0;
      brk   = !irq && cause == 32'd3 && ebrk[prv];
      if (brk) begin
         e.pc = DROM; e.priv = 2'd3; e.wdbg = 1; e.dcause = 3'd1; e.dprv = prv; e.epc = cur_pc;
      end else if (dbgc != 3'd0) begin
         e.pc = DEXC;
      end else begin
         dg = (prv <= 2'd1) && (irq ? ideleg[idx] : (cause < 32 && edeleg[cause[4:0]]));
         e.cause = cause; e.epc = epc; e.bwe = !irq && bad_vld; e.bad = exc_bad; e.resv = 1;
         if (dg) begin
            e.pc = stvec; e.priv = 2'd1; e.wsup = 1; e.spie = pie; e.spp = prv[0]; e.sie = 0;
         end else begin
            e.pc = mtvec; e.priv = 2'd3; e.wmach = 1; e.mpie = pie; e.mpp = prv; e.mie = 0;
         end
      end
      return e;
   endfunction

   task automatic idle();
      prv = 2'd3; cur_pc = 32'h1000_0000; stvec = 32'h0000_4000; mtvec = 32'h0000_8000;
      pend = '0; ien = '0; ideleg = '0; edeleg = '0;
      uie = 0; sie_s = 0; spie_s = 0; spp_s = 0; mie_s = 0; mpie_s = 0; mpp_s = 2'd0;
      ebrk = '0; dbgc = '0; exc_req = 0; exc_cause = '0; exc_epc = 32'h2000_0000;
      bad_vld = 0; exc_bad = '0;
   endtask

   // driver: push the expectation for the current inputs, then let one edge pass
   task automatic go(string tag);
      sb_q.push_back(model(tag));
      @(negedge clk);
   endtask

   function automatic bit fld(string tag, string name, logic [31:0] act, logic [31:0] exp);
      if (act !== exp) begin
         $display("FAIL %s field %s act=%0h exp=%0h", tag, name, act, exp);
         return 1'b1;
      end
      return 1'b0;
   endfunction

   // monitor: one expectation per edge, compared just after the edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb_q.size() > 0) begin
            exp_t e;
            bit   bad;
            e   = sb_q.pop_front();
            bad = 0;
            bad |= fld(e.tag, "upd_vld", 32'(o_vld), 32'(e.vld));
            bad |= fld(e.tag, "resv_clr R13", 32'(o_resv), 32'(e.resv));
            bad |= fld(e.tag, "wr_sup", 32'(o_wsup), 32'(e.wsup));
            bad |= fld(e.tag, "wr_mach", 32'(o_wmach), 32'(e.wmach));
            bad |= fld(e.tag, "wr_dbg", 32'(o_wdbg), 32'(e.wdbg));
            bad |= fld(e.tag, "bad_we R12", 32'(o_bwe), 32'(e.bwe));
            if (e.vld) begin
               bad |= fld(e.tag, "pc", o_pc, e.pc);
               bad |= fld(e.tag, "priv", 32'(o_priv), 32'(e.priv));
               bad |= fld(e.tag, "sie", 32'(o_sie), 32'(e.sie));
               bad |= fld(e.tag, "spie", 32'(o_spie), 32'(e.spie));
               bad |= fld(e.tag, "spp", 32'(o_spp), 32'(e.spp));
               bad |= fld(e.tag, "mie", 32'(o_mie), 32'(e.mie));
               bad |= fld(e.tag, "mpie", 32'(o_mpie), 32'(e.mpie));
               bad |= fld(e.tag, "mpp", 32'(o_mpp), 32'(e.mpp));
            end
            if (e.wsup || e.wmach) begin
               bad |= fld(e.tag, "cause", o_cause, e.cause);
               bad |= fld(e.tag, "epc", o_epc, e.epc);
               if (e.bwe) bad |= fld(e.tag, "bad", o_bad, e.bad);
            end
            if (e.wdbg) begin
               bad |= fld(e.tag, "dpc", o_epc, e.epc);
               bad |= fld(e.tag, "dbg_cause", 32'(o_dcause), 32'(e.dcause));
               bad |= fld(e.tag, "dbg_prv", 32'(o_dprv), 32'(e.dprv));
            end
            n_cmp++;
            if (bad) n_bad++;
         end
      end
   end

   task automatic reset_check(string tag);
      n_cmp++;
      if ({o_vld, o_resv, o_wsup, o_wmach, o_wdbg, o_bwe} !== 6'b0) begin
         n_bad++;
         $display("FAIL %s reset outputs act=%b exp=000000", tag,
                  {o_vld, o_resv, o_wsup, o_wmach, o_wdbg, o_bwe});
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         done = 1'b1;
         n_bad++;
         $display("FAIL watchdog expired act=running exp=finished");
         summary();
         $finish;
      end
   end

   initial begin
      idle();
      exc_req = 1; exc_cause = 32'd2;            // request held during reset
      repeat (3) @(negedge clk);
      reset_check("R1 during reset");
      rst_n = 1'b1;
      idle();
      @(posedge clk); #1;
      reset_check("R1 first cycle after reset");
      @(negedge clk);

      // R2: pending without enable, enable without pending
      idle(); pend = 12'h020; mie_s = 1; go("R2 pending not enabled");
      idle(); ien = 12'h020; mie_s = 1; go("R2 enabled not pending");
      // R3 / R11: machine interrupt at machine level
      idle(); pend = 12'h020; ien = 12'h020; mie_s = 1; mpp_s = 2'd0; go("R3 R11 machine irq mie set");
      idle(); pend = 12'h020; ien = 12'h020; mie_s = 0; go("R3 machine level mie clear");
      idle(); prv = 2'd0; pend = 12'h020; ien = 12'h020; uie = 1; go("R3 user level mie clear");
      // R5: lowest index wins
      idle(); pend = 12'h028; ien = 12'hFFF; mie_s = 1; go("R5 lowest of two");
      idle(); prv = 2'd1; pend = 12'h084; ien = 12'h084; ideleg = 12'h004; sie_s = 0; mie_s = 1;
      go("R5 R4 delegated low bit masked");
      // R4: delegated interrupt enable rules
      idle(); prv = 2'd1; pend = 12'h002; ien = 12'h002; ideleg = 12'h002; sie_s = 0; go("R4 super sie clear");
      idle(); prv = 2'd1; pend = 12'h002; ien = 12'h002; ideleg = 12'h002; sie_s = 1; spp_s = 0;
      go("R4 R10 super sie set");
      idle(); prv = 2'd0; pend = 12'h002; ien = 12'h002; ideleg = 12'h002; uie = 1; go("R4 R10 user level");
      idle(); prv = 2'd3; pend = 12'h002; ien = 12'h002; ideleg = 12'h002; mie_s = 1; sie_s = 1;
      go("R4 machine level delegated");
      // R9 / R10 / R12: exceptions
      idle(); prv = 2'd0; exc_req = 1; exc_cause = 32'd13; edeleg = 32'h0000_2000; uie = 1;
      bad_vld = 1; exc_bad = 32'hDEAD_0010; go("R9 R10 R12 user delegated with address");
      idle(); prv = 2'd3; exc_req = 1; exc_cause = 32'd13; edeleg = 32'h0000_2000; mie_s = 1;
      go("R9 R11 machine ignores delegation");
      idle(); prv = 2'd1; exc_req = 1; exc_cause = 32'd5; sie_s = 1; mpie_s = 0; mpp_s = 2'd3;
      bad_vld = 0; exc_bad = 32'h1234_5678; go("R11 R12 super undelegated no address");
      idle(); prv = 2'd0; exc_req = 1; exc_cause = 32'd33; edeleg = 32'h0000_0002;
      go("R9 cause beyond width");
      // R6: interrupt beats exception
      idle(); prv = 2'd3; mie_s = 1; pend = 12'h800; ien = 12'h800; exc_req = 1; exc_cause = 32'd2;
      bad_vld = 1; exc_bad = 32'h55; go("R6 irq over exception");
      // R7 / R8: debug
      idle(); prv = 2'd1; exc_req = 1; exc_cause = 32'd3; ebrk = 4'b0010; cur_pc = 32'h1000_0044;
      go("R7 breakpoint to debug");
      idle(); prv = 2'd1; exc_req = 1; exc_cause = 32'd3; ebrk = 4'b1001; go("R7 breakpoint other level");
      idle(); prv = 2'd0; exc_req = 1; exc_cause = 32'd8; dbgc = 3'd3; edeleg = 32'h100;
      go("R8 exception in debug");
      idle(); prv = 2'd3; mie_s = 1; pend = 12'h001; ien = 12'h001; dbgc = 3'd1; go("R8 irq in debug");
      idle(); prv = 2'd3; exc_req = 1; exc_cause = 32'd3; ebrk = 4'b1000; dbgc = 3'd2;
      go("R8 R7 breakpoint precedence");
      // back-to-back mixed traffic
      for (int k = 0; k < 80; k++) begin
         logic [1:0] pick;
         idle();
         pick    = 2'($urandom % 3);
         prv     = (pick == 2'd2) ? 2'd3 : pick;
         pend    = 12'($urandom) & 12'h0F5;
         ien     = 12'($urandom);
         ideleg  = 12'($urandom);
         edeleg  = $urandom;
         {uie, sie_s, spie_s, spp_s, mie_s, mpie_s} = 6'($urandom);
         mpp_s   = 2'($urandom);
         ebrk    = 4'($urandom);
         dbgc    = ($urandom % 6 == 0) ? 3'd4 : 3'd0;
         exc_req = 1'($urandom);
         exc_cause = 32'($urandom % 40);
         exc_epc = $urandom; cur_pc = $urandom; stvec = $urandom; mtvec = $urandom;
         bad_vld = 1'($urandom); exc_bad = $urandom;
         go("R5 R9 R13 mixed");
      end
      idle();
      @(posedge clk); #3;
      if (!done) begin
         done = 1'b1;
         summary();
         $finish;
      end
   end

endmodule